// File: doc/BRIEF.md
# Thread System-Side Controller

This block is the system-side controller of a hardware thread. It sits behind a memory-mapped bus slave port, keeps the thread's control registers (identifier, command, status, argument, result), and gives the bus word-wide access to the thread's local memory through one port of a dual-port RAM that lives outside the block. A thread's user-side controller, which runs the thread's work, cannot write the status register directly. It posts a status-change code on a request input and holds that code until it sees the status output take the new value.

A fixed-priority loop runs in the idle state. A bus write goes first, a bus read second, and the internal status request is served only on a cycle with no bus traffic. Each bus access ends with a single-cycle acknowledge. A local-memory read takes one extra cycle because the RAM is synchronous. A timer value kept elsewhere can be read through the same register window. Writing the reset command code to the command register sends the controller back through its initialisation state, which clears every register it owns.

Top module: `thread_sys_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, bus_ack and mem_en are low, status_o is 0 (idle), and the identifier, command, status, argument and result registers read 0.
- R2: Word offsets 0x00 identifier, 0x04 command, 0x08 status, 0x0C argument, 0x10 result and 0x14 timer form the register window. Identifier, command, argument and result return the last value written to them.
- R3: Status (0x08) and timer (0x14) cannot be written from the bus. A write to either leaves the readback unchanged. The timer always returns timer_i.
- R4: An address that is misaligned (low two bits not 00), or that lies neither in the register window nor in the memory window, reads 0 and ignores writes. The access is still acknowledged, and mem_en stays low.
- R5: A register access accepted in idle raises bus_ack in the next cycle for exactly one cycle. Read data is valid on bus_rdata in that same cycle.
- R6: A write to address 0x1000 + 4*i, with i below the memory depth, drives mem_en, mem_we, mem_addr = i and mem_wdata in its acknowledge cycle, one cycle after acceptance.
- R7: A memory read presents mem_addr with mem_en high and mem_we low for one cycle. bus_ack and the RAM data follow in the next cycle, two cycles after acceptance.
- R8: Request code 1 sets status to 1 (running) and code 2 sets it to 2 (exited). On a quiet bus, status_o shows the new value two cycles after the code is first presented.
- R9: Request codes 0 and 3 never change the status, and they do not delay bus accesses.
- R10: In idle, a bus write beats a bus read, and any bus access beats a pending status request. The request is served only after the bus access has finished.
- R11: A request whose target equals the current status is not served again, so holding it does not delay bus accesses.
- R12: Writing 1 to the command register clears the identifier, command, status, argument and result registers one cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Bus write request, held until acknowledge |
| bus_rd | input | 1 | Bus read request, held until acknowledge |
| bus_addr | input | ADDR_W (16) | Byte address of the access |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, valid with bus_ack |
| bus_ack | output | 1 | One-cycle access acknowledge |
| sys_req | input | 2 | Status-change code from the user-side controller |
| status_o | output | 2 | Current thread status |
| timer_i | input | DATA_W (32) | Externally kept timer value |
| mem_en | output | 1 | RAM port enable |
| mem_we | output | 1 | RAM port write enable |
| mem_addr | output | MEM_AW (10) | RAM word index |
| mem_wdata | output | DATA_W (32) | RAM write data |
| mem_rdata | input | DATA_W (32) | RAM read data, one cycle after address |

## Verification
A register access or memory write is due one cycle after the idle cycle that accepts it, a memory read two cycles after, and a status update two cycles after the request code appears on a quiet bus. A request that competes with a bus write lands four cycles after both are presented. The bench drives on falling edges and counts cycles one rising edge at a time, sampling on the following falling edge. Each latency is therefore an exact count, and the bench compares it with the expected number rather than waiting for some result.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

  typedef enum logic [2:0] {
    S_INIT,
    S_IDLE,
    S_REG_WR,
    S_REG_RD,
    S_MEM_WR,
    S_MEM_RD,
    S_MEM_WAIT,
    S_SREQ
  } fsm_state_e;

  typedef enum logic [1:0] {
    RG_NONE,
    RG_REG,
    RG_MEM
  } region_e;

  typedef enum logic [2:0] {
    IX_TID  = 3'd0,
    IX_CMD  = 3'd1,
    IX_STAT = 3'd2,
    IX_ARG  = 3'd3,
    IX_RES  = 3'd4,
    IX_TMR  = 3'd5,
    IX_NA6  = 3'd6,
    IX_NA7  = 3'd7
  } reg_idx_e;

  localparam logic [1:0] STAT_IDLE = 2'd0;
  localparam logic [1:0] STAT_RUN  = 2'd1;
  localparam logic [1:0] STAT_EXIT = 2'd2;

  localparam logic [1:0] REQ_NONE = 2'd0;
  localparam logic [1:0] REQ_RUN  = 2'd1;
  localparam logic [1:0] REQ_EXIT = 2'd2;

  localparam int CMD_RESET_CODE = 1;

  function automatic logic req_valid(input logic [1:0] code);
    return (code == REQ_RUN) || (code == REQ_EXIT);
  endfunction

  function automatic logic [1:0] req_target(input logic [1:0] code);
    logic [1:0] t;
    case (code)
      REQ_RUN:  t = STAT_RUN;
      REQ_EXIT: t = STAT_EXIT;
      default:  t = STAT_IDLE;
    endcase
    return t;
  endfunction

endpackage

// File: rtl/tsc_addr_dec.sv
module tsc_addr_dec
  import tsc_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter int                MEM_WORDS = 1024,
  parameter int                MEM_AW    = 10,
  parameter logic [ADDR_W-1:0] MEM_BASE  = 16'h1000
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output reg_idx_e          idx,
  output logic [MEM_AW-1:0] word
);

  localparam logic [ADDR_W:0] MEM_SPAN = (ADDR_W+1)'(MEM_WORDS * 4);

  logic [ADDR_W-1:0] off;
  logic              aligned;
  logic              in_mem;
  logic              in_reg;

  always_comb begin
    off     = addr - MEM_BASE;
    aligned = (addr[1:0] == 2'b00);
    in_mem  = (addr >= MEM_BASE) && ({1'b0, off} < MEM_SPAN);
    in_reg  = (addr[ADDR_W-1:5] == '0) && (addr[4:2] <= IX_TMR);
    idx     = reg_idx_e'(addr[4:2]);
    word    = off[MEM_AW+1:2];
    if (!aligned)    region = RG_NONE;
    else if (in_mem) region = RG_MEM;
    else if (in_reg) region = RG_REG;
    else             region = RG_NONE;
  end

endmodule

// File: rtl/tsc_regs.sv
module tsc_regs
  import tsc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              wr_en,
  input  reg_idx_e          wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              st_set,
  input  logic [1:0]        st_val,
  input  logic [DATA_W-1:0] timer_i,
  input  reg_idx_e          rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic [1:0]        status_o
);

  logic [DATA_W-1:0] tid_q, cmd_q, arg_q, res_q;
  logic [1:0]        stat_q;
  logic              we_tid, we_cmd, we_arg, we_res;

  always_comb begin
    we_tid = wr_en && (wr_idx == IX_TID);
    we_cmd = wr_en && (wr_idx == IX_CMD);
    we_arg = wr_en && (wr_idx == IX_ARG);
    we_res = wr_en && (wr_idx == IX_RES);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tid_q  <= '0;
      cmd_q  <= '0;
      arg_q  <= '0;
      res_q  <= '0;
      stat_q <= STAT_IDLE;
    end else if (clear) begin
      tid_q  <= '0;
      cmd_q  <= '0;
      arg_q  <= '0;
      res_q  <= '0;
      stat_q <= STAT_IDLE;
    end else begin
      if (we_tid) tid_q  <= wr_data;
      if (we_cmd) cmd_q  <= wr_data;
      if (we_arg) arg_q  <= wr_data;
      if (we_res) res_q  <= wr_data;
      if (st_set) stat_q <= st_val;
    end
  end

  always_comb begin
    case (rd_idx)
      IX_TID:  rd_data = tid_q;
      IX_CMD:  rd_data = cmd_q;
      IX_STAT: rd_data = DATA_W'(stat_q);
      IX_ARG:  rd_data = arg_q;
      IX_RES:  rd_data = res_q;
      IX_TMR:  rd_data = timer_i;
      default: rd_data = '0;
    endcase
  end

  assign status_o = stat_q;

endmodule

// File: rtl/tsc_fsm.sv
module tsc_fsm
  import tsc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  region_e           region,
  input  reg_idx_e          idx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [1:0]        sys_req,
  input  logic [1:0]        status,
  output logic              clear,
  output logic              reg_we,
  output logic              rd_reg,
  output logic              rd_mem,
  output logic              mem_en,
  output logic              mem_we,
  output logic              st_set,
  output logic [1:0]        st_val,
  output logic              ack,
  output logic              idle
);

  localparam logic [DATA_W-1:0] RESET_CODE = DATA_W'(CMD_RESET_CODE);

  fsm_state_e st_q, st_nxt;
  logic       req_ok;
  logic       go_req;
  logic       is_reset_cmd;

  always_comb begin
    req_ok       = req_valid(sys_req);
    go_req       = req_ok && (req_target(sys_req) != status);
    is_reset_cmd = (region == RG_REG) && (idx == IX_CMD) && (wdata == RESET_CODE);
  end

  // Next-state logic: fixed priority in idle (write, read, then mailbox)
  always_comb begin
    st_nxt = st_q;
    case (st_q)
      S_INIT: st_nxt = S_IDLE;
      S_IDLE: begin
        if (bus_wr)      st_nxt = (region == RG_MEM) ? S_MEM_WR : S_REG_WR;
        else if (bus_rd) st_nxt = (region == RG_MEM) ? S_MEM_RD : S_REG_RD;
        else if (go_req) st_nxt = S_SREQ;
      end
      S_REG_WR: st_nxt = is_reset_cmd ? S_INIT : S_IDLE;
      S_MEM_RD: st_nxt = S_MEM_WAIT;
      default:  st_nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= S_INIT;
    else        st_q <= st_nxt;
  end

  always_comb begin
    clear  = (st_q == S_INIT);
    reg_we = (st_q == S_REG_WR) && (region == RG_REG);
    rd_reg = (st_q == S_REG_RD) && (region == RG_REG);
    rd_mem = (st_q == S_MEM_WAIT);
    mem_en = (st_q == S_MEM_WR) || (st_q == S_MEM_RD);
    mem_we = (st_q == S_MEM_WR);
    st_set = (st_q == S_SREQ) && req_ok;
    st_val = req_target(sys_req);
    ack    = (st_q == S_REG_WR) || (st_q == S_REG_RD) ||
             (st_q == S_MEM_WR) || (st_q == S_MEM_WAIT);
    idle   = (st_q == S_IDLE);
  end

endmodule

// File: rtl/thread_sys_ctrl.sv
module thread_sys_ctrl
  import tsc_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter int                DATA_W    = 32,
  parameter int                MEM_WORDS = 1024,
  parameter logic [ADDR_W-1:0] MEM_BASE  = 16'h1000,
  localparam int               MEM_AW    = $clog2(MEM_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_ack,
  input  logic [1:0]        sys_req,
  output logic [1:0]        status_o,
  input  logic [DATA_W-1:0] timer_i,
  output logic              mem_en,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  region_e           region;
  reg_idx_e          idx;
  logic [MEM_AW-1:0] word;
  logic              clear, reg_we, rd_reg, rd_mem, st_set, fsm_idle;
  logic [1:0]        st_val;
  logic [DATA_W-1:0] reg_rdata;

  tsc_addr_dec #(
    .ADDR_W   (ADDR_W),
    .MEM_WORDS(MEM_WORDS),
    .MEM_AW   (MEM_AW),
    .MEM_BASE (MEM_BASE)
  ) u_dec (
    .addr  (bus_addr),
    .region(region),
    .idx   (idx),
    .word  (word)
  );

  tsc_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .bus_wr (bus_wr),
    .bus_rd (bus_rd),
    .region (region),
    .idx    (idx),
    .wdata  (bus_wdata),
    .sys_req(sys_req),
    .status (status_o),
    .clear  (clear),
    .reg_we (reg_we),
    .rd_reg (rd_reg),
    .rd_mem (rd_mem),
    .mem_en (mem_en),
    .mem_we (mem_we),
    .st_set (st_set),
    .st_val (st_val),
    .ack    (bus_ack),
    .idle   (fsm_idle)
  );

  tsc_regs #(.DATA_W(DATA_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .clear   (clear),
    .wr_en   (reg_we),
    .wr_idx  (idx),
    .wr_data (bus_wdata),
    .st_set  (st_set),
    .st_val  (st_val),
    .timer_i (timer_i),
    .rd_idx  (idx),
    .rd_data (reg_rdata),
    .status_o(status_o)
  );

  assign mem_addr  = word;
  assign mem_wdata = bus_wdata;

  always_comb begin
    if (rd_mem)      bus_rdata = mem_rdata;
    else if (rd_reg) bus_rdata = reg_rdata;
    else             bus_rdata = '0;
  end

endmodule

// File: rtl/tsc_chk.sv
module tsc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic       bus_ack,
  input logic       mem_en,
  input logic       mem_we,
  input logic [1:0] status_o,
  input logic [1:0] sys_req,
  input logic       in_idle
);

  p_ack_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack |=> !bus_ack);

  p_mem_wr_acked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we) |-> bus_ack);

  p_mem_rd_late_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !mem_we) |-> (!bus_ack ##1 bus_ack));

  p_status_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    status_o != 2'd3);

  p_status_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(status_o) |-> ((status_o == 2'd0) || ($past(sys_req) != 2'd0)));

  p_bus_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_idle && (bus_wr || bus_rd)) |=> $stable(status_o));

endmodule

bind thread_sys_ctrl tsc_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .bus_wr  (bus_wr),
  .bus_rd  (bus_rd),
  .bus_ack (bus_ack),
  .mem_en  (mem_en),
  .mem_we  (mem_we),
  .status_o(status_o),
  .sys_req (sys_req),
  .in_idle (fsm_idle)
);

// File: tb/sim_thread_sys_ctrl.sv
`timescale 1ns/1ps
module sim_thread_sys_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int WORDS      = 1024;
  localparam logic [15:0] A_TID = 16'h0000, A_CMD = 16'h0004, A_STAT = 16'h0008,
                          A_ARG = 16'h000C, A_RES = 16'h0010, A_TMR  = 16'h0014,
                          A_MEM = 16'h1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_ack;
  logic [1:0]  sys_req = 2'd0;
  logic [1:0]  status_o;
  logic [31:0] timer_i = 32'h0000_0000;
  logic        mem_en, mem_we;
  logic [9:0]  mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata;

  int n_chk = 0;
  int n_fail = 0;
  int mem_acc = 0;
  logic [31:0] ram [WORDS];

  always #(CLK_PERIOD/2) clk = ~clk;

  thread_sys_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ack(bus_ack), .sys_req(sys_req), .status_o(status_o),
    .timer_i(timer_i), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // Synchronous RAM model for the other side of the port
  always @(posedge clk) begin
    if (mem_en === 1'b1) begin
      mem_acc <= mem_acc + 1;
      if (mem_we) ram[mem_addr] <= mem_wdata;
      mem_rdata <= ram[mem_addr];
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [31:0] d, output int lat);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1; lat = 0;
    while (lat < 16) begin
      @(posedge clk); @(negedge clk); lat++;
      if (bus_ack) break;
    end
    bus_wr = 1'b0; bus_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic bus_read(input logic [15:0] a, output logic [31:0] d, output int lat);
    bus_addr = a; bus_rd = 1'b1; lat = 0; d = 'x;
    while (lat < 16) begin
      @(posedge clk); @(negedge clk); lat++;
      if (bus_ack) begin d = bus_rdata; break; end
    end
    bus_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(bus_ack == 1'b0 && mem_en == 1'b0, "R1 outputs in reset", {30'd0, bus_ack, mem_en}, 32'd0);
    chk(status_o == 2'd0, "R1 status in reset", 32'(status_o), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    begin
      logic [31:0] d; int lat;
      foreach (ram[i]) ram[i] = 32'(i) ^ 32'h5A00_0000;
      bus_read(A_TID, d, lat);  chk(d == 0, "R1 tid after reset", d, 0);
      bus_read(A_CMD, d, lat);  chk(d == 0, "R1 cmd after reset", d, 0);
      bus_read(A_STAT, d, lat); chk(d == 0, "R1 status after reset", d, 0);
      bus_read(A_ARG, d, lat);  chk(d == 0, "R1 arg after reset", d, 0);
      bus_read(A_RES, d, lat);  chk(d == 0, "R1 result after reset", d, 0);
    end
  endtask

  task automatic t_regmap();
    logic [31:0] d; int lat;
    bus_write(A_TID, 32'h0000_0017, lat); chk(lat == 1, "R5 write ack latency", lat, 1);
    bus_write(A_CMD, 32'h0000_00A5, lat);
    bus_write(A_ARG, 32'hDEAD_BEEF, lat);
    bus_write(A_RES, 32'h1234_5678, lat);
    bus_read(A_TID, d, lat); chk(d == 32'h17, "R2 tid readback", d, 32'h17);
    chk(lat == 1, "R5 read ack latency", lat, 1);
    bus_read(A_CMD, d, lat); chk(d == 32'hA5, "R2 cmd readback", d, 32'hA5);
    bus_read(A_ARG, d, lat); chk(d == 32'hDEAD_BEEF, "R2 arg readback", d, 32'hDEAD_BEEF);
    bus_read(A_RES, d, lat); chk(d == 32'h1234_5678, "R2 result readback", d, 32'h1234_5678);
    // ack must drop after one cycle (checked one cycle after the ack cycle)
    bus_addr = A_ARG; bus_rd = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(bus_ack == 1'b1, "R5 ack high", 32'(bus_ack), 1);
    @(posedge clk); @(negedge clk);
    chk(bus_ack == 1'b0, "R5 ack single cycle", 32'(bus_ack), 0);
    bus_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_readonly();
    logic [31:0] d; int lat;
    timer_i = 32'hCAFE_0042;
    bus_write(A_STAT, 32'h2, lat);
    bus_read(A_STAT, d, lat); chk(d == 0, "R3 status not bus-writable", d, 0);
    bus_write(A_TMR, 32'h1111_1111, lat);
    bus_read(A_TMR, d, lat); chk(d == 32'hCAFE_0042, "R3 timer follows input", d, 32'hCAFE_0042);
  endtask

  task automatic t_unmapped();
    logic [31:0] d; int lat; int acc0;
    acc0 = mem_acc;
    bus_write(16'h0018, 32'h9999_9999, lat); chk(lat == 1, "R4 unmapped write acked", lat, 1);
    bus_read(16'h0018, d, lat); chk(d == 0, "R4 unmapped reads zero", d, 0);
    bus_write(16'h0002, 32'hFFFF_FFFF, lat);
    bus_read(A_TID, d, lat); chk(d == 32'h17, "R4 misaligned write ignored", d, 32'h17);
    bus_read(16'h2000, d, lat); chk(d == 0 && lat == 1, "R4 beyond memory reads zero", d, 0);
    bus_write(16'h2000, 32'h7777_7777, lat);
    chk(mem_acc == acc0, "R4 no RAM access", 32'(mem_acc - acc0), 0);
  endtask

  task automatic t_mem();
    logic [31:0] d; int lat;
    bus_write(A_MEM + 16'd20, 32'hA0A0_0005, lat);
    chk(lat == 1, "R6 memory write latency", lat, 1);
    chk(ram[5] == 32'hA0A0_0005, "R6 word 5 written", ram[5], 32'hA0A0_0005);
    bus_write(16'h1FFC, 32'hB0B0_03FF, lat);
    chk(ram[1023] == 32'hB0B0_03FF, "R6 last word written", ram[1023], 32'hB0B0_03FF);
    bus_read(A_MEM + 16'd20, d, lat);
    chk(d == 32'hA0A0_0005, "R7 memory read data", d, 32'hA0A0_0005);
    chk(lat == 2, "R7 memory read latency", lat, 2);
    bus_read(A_MEM + 16'd12, d, lat);
    chk(d == (32'd3 ^ 32'h5A00_0000), "R7 preloaded word 3", d, 32'd3 ^ 32'h5A00_0000);
  endtask

  task automatic t_sreq(input logic [1:0] code, input logic [1:0] exp_st);
    logic [1:0] st0; int lat;
    st0 = status_o; sys_req = code; lat = 0;
    while (lat < 8) begin
      @(posedge clk); @(negedge clk); lat++;
      if (status_o != st0) break;
    end
    sys_req = 2'd0;
    chk(status_o == exp_st, "R8 status after request", 32'(status_o), 32'(exp_st));
    chk(lat == 2, "R8 request latency", lat, 2);
    @(negedge clk);
  endtask

  task automatic t_ignored_codes();
    logic [1:0] st0; int lat;
    st0 = status_o;
    sys_req = 2'd3;
    repeat (4) @(negedge clk);
    chk(status_o == st0, "R9 code 3 ignored", 32'(status_o), 32'(st0));
    bus_write(A_ARG, 32'h3333_0003, lat); chk(lat == 1, "R9 code 3 no bus delay", lat, 1);
    bus_write(A_ARG, 32'h3333_0004, lat); chk(lat == 1, "R9 code 3 no bus delay 2", lat, 1);
    sys_req = 2'd0;
    repeat (3) @(negedge clk);
    chk(status_o == st0, "R9 code 0 ignored", 32'(status_o), 32'(st0));
  endtask

  task automatic t_no_reserve();
    int lat;
    sys_req = 2'd1;
    repeat (3) @(negedge clk);
    bus_write(A_RES, 32'h0000_0111, lat); chk(lat == 1, "R11 held request no delay", lat, 1);
    bus_write(A_RES, 32'h0000_0222, lat); chk(lat == 1, "R11 held request no delay 2", lat, 1);
    sys_req = 2'd0;
  endtask

  task automatic t_priority();
    logic [31:0] d; int lat; int ack_at; int chg_at;
    bus_addr = A_ARG; bus_wdata = 32'h5555_AAAA; bus_wr = 1'b1; sys_req = 2'd2;
    ack_at = 0; chg_at = 0;
    for (int c = 1; c <= 8; c++) begin
      @(posedge clk); @(negedge clk);
      if (bus_ack && ack_at == 0) begin ack_at = c; bus_wr = 1'b0; end
      if (status_o == 2'd2 && chg_at == 0) begin chg_at = c; sys_req = 2'd0; end
    end
    bus_wr = 1'b0; sys_req = 2'd0;
    chk(ack_at == 1, "R10 bus write served first", ack_at, 1);
    chk(chg_at == 4, "R10 request served after bus", chg_at, 4);
    // write beats read when both are raised
    bus_rd = 1'b1;
    bus_write(A_ARG, 32'h0BAD_F00D, lat);
    chk(lat == 1, "R10 write-over-read ack", lat, 1);
    bus_read(A_ARG, d, lat); chk(d == 32'h0BAD_F00D, "R10 write took priority", d, 32'h0BAD_F00D);
  endtask

  task automatic t_reset_cmd();
    logic [31:0] d; int lat;
    chk(status_o == 2'd2, "R12 precondition status exited", 32'(status_o), 2);
    bus_write(A_CMD, 32'h0000_0001, lat);
    repeat (2) @(negedge clk);
    chk(status_o == 2'd0, "R12 status cleared", 32'(status_o), 0);
    bus_read(A_TID, d, lat); chk(d == 0, "R12 tid cleared", d, 0);
    bus_read(A_CMD, d, lat); chk(d == 0, "R12 cmd cleared", d, 0);
    bus_read(A_ARG, d, lat); chk(d == 0, "R12 arg cleared", d, 0);
    bus_read(A_RES, d, lat); chk(d == 0, "R12 result cleared", d, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1;
    @(negedge clk);
    t_reset();
    t_regmap();
    t_readonly();
    t_unmapped();
    t_mem();
    t_sreq(2'd1, 2'd1);
    t_ignored_codes();
    t_no_reserve();
    t_priority();
    t_reset_cmd();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule